// File: doc/BRIEF.md
# Interrupt-Gated Power State Controller

This block decides when a small system may stop its processor clock or its main oscillator. Software asks for a low-power state by writing to one of two request addresses on a simple write bus. The data is ignored. One request gates the processor clock off (Idle). The other halts the main oscillator as well (Standby). The controller runs on an always-on reference clock, so it keeps watching interrupts while the processor sleeps.

Six interrupt sources feed edge-triggered latches. Each latch has its own end-of-interrupt address, and any write there clears it. The OR of the latches is the pending signal. Pending blocks entry into either low-power state, and it also ends Idle.

Standby ends on a dedicated wake input, or on a latched interrupt whose wake-mask bit is set. After Standby ends, the oscillator runs again but the processor clock stays off for a programmable number of settling cycles. Standby entry is refused while the display controller reports itself enabled, and each refused attempt raises a violation pulse.

All pins are plain control and status lines. The bus is a write strobe with no back-pressure: every write is taken in the cycle it is presented.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the state is Operating (code 0), `cpu_clk_en` and `osc_en` are 1, all latches are 0 and `irq_pending` is 0.
- R2: A write to 0x0800 in Operating, with no latch set, moves to Idle (code 1) at the next edge. In Idle, `cpu_clk_en` is 0 and `osc_en` is 1.
- R3: In Idle, the edge after any latch becomes set returns the state to Operating with `cpu_clk_en` = 1.
- R4: A write to 0x0840 in Operating, with no latch set and `disp_en_i` = 0, moves to Standby (code 2) at the next edge. In Standby, `cpu_clk_en` and `osc_en` are both 0.
- R5: A write to 0x0800 or 0x0840 while any latch is set is ignored, and the state stays Operating.
- R6: A write to 0x0840 while `disp_en_i` = 1 never enters Standby. `disp_violation` is 1 for exactly the one cycle after that write.
- R7: A rising edge on `irq_src[i]` sets latch i at that edge. A source held high does not set the latch again after it has been cleared.
- R8: A write of any data clears only the latch that owns the address: bit 0 at 0x0700, bit 1 at 0x0740, bit 2 at 0x0780, bit 3 at 0x07C0, bit 4 at 0x1700, bit 5 at 0x1600. These clears work in every state.
- R9: When a rising edge and a clear for the same latch occur in one cycle, the latch ends up set.
- R10: Standby is left only when `wake_i` = 1, or when a latch i is set with `irq_wake_mask[i]` = 1. An unmasked latch leaves the state in Standby.
- R11: On leaving Standby with `settle_cycles` = N > 0, the state is Waking (code 3) for exactly N cycles, with `osc_en` = 1 and `cpu_clk_en` = 0, and then Operating. With N = 0 the state goes straight to Operating.
- R12: `status[1:0]` holds the state code and `status[7:2]` holds latches 5..0. `irq_pending` is the OR of the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Bus write address |
| irq_src | input | NSRC | Interrupt source lines, rising-edge sensitive |
| irq_wake_mask | input | NSRC | Selects which latches may end Standby |
| wake_i | input | 1 | Dedicated Standby wake request |
| disp_en_i | input | 1 | Display controller enabled, blocks Standby |
| settle_cycles | input | CNT_W | Oscillator settling count after Standby |
| cpu_clk_en | output | 1 | Processor clock enable |
| osc_en | output | 1 | Main oscillator enable |
| irq_pending | output | 1 | Any latch set |
| disp_violation | output | 1 | One-cycle pulse when Standby is refused because of the display |
| status | output | NSRC+2 | Latches above the two-bit state code |

## Verification
Some corner cases involve a latch set and a low-power request on the same cycle. A design that tested the incoming edge instead of the registered latches would drop into Idle when it should stay in Operating, or behave the other way round.

A set and a clear that coincide on one latch must leave it set. A design that favours the clear would lose an interrupt.

The bench also holds a source high across its clear. A design that is level-sensitive would refire the latch at once.

Standby exit is driven with a zero settling count and with a nonzero count. An off-by-one counter would show the wrong number of Waking cycles, or would enter Waking when the count is zero. An unmasked interrupt in Standby must not wake the system.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_IDLE = 2'd1,
    PS_STBY = 2'd2,
    PS_WAKE = 2'd3
  } pstate_e;

  localparam logic [15:0] IDLE_REQ_ADDR = 16'h0800;
  localparam logic [15:0] STBY_REQ_ADDR = 16'h0840;

  // End-of-interrupt address for latch index i
  function automatic logic [15:0] eoi_addr(input int i);
    case (i)
      0:       eoi_addr = 16'h0700;
      1:       eoi_addr = 16'h0740;
      2:       eoi_addr = 16'h0780;
      3:       eoi_addr = 16'h07C0;
      4:       eoi_addr = 16'h1700;
      5:       eoi_addr = 16'h1600;
      default: eoi_addr = 16'hFFFF;
    endcase
  endfunction

endpackage

// File: rtl/pwr_addr_decode.sv
module pwr_addr_decode
  import pwr_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NSRC   = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NSRC-1:0]   clr_vec,
  output logic              idle_req,
  output logic              stby_req
);

  localparam logic [ADDR_W-1:0] IDLE_A = ADDR_W'(IDLE_REQ_ADDR);
  localparam logic [ADDR_W-1:0] STBY_A = ADDR_W'(STBY_REQ_ADDR);

  for (genvar i = 0; i < NSRC; i++) begin : g_eoi
    localparam logic [ADDR_W-1:0] EOI_A = ADDR_W'(eoi_addr(i));
    assign clr_vec[i] = wr_en && (wr_addr == EOI_A);
  end

  assign idle_req = wr_en && (wr_addr == IDLE_A);
  assign stby_req = wr_en && (wr_addr == STBY_A);

endmodule

// File: rtl/pwr_irq_bank.sv
module pwr_irq_bank #(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] flags
);

  logic [NSRC-1:0] src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_latch
    logic rise;
    assign rise = src[i] && !src_q[i];
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (rise)   flags[i] <= 1'b1;   // set dominates clear
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_ctrl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             stby_req,
  input  logic             pending,
  input  logic             wake_hit,
  input  logic             disp_en,
  input  logic [CNT_W-1:0] settle,
  output pstate_e          state,
  output logic             violation
);

  pstate_e          st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = state;
    cnt_d = cnt_q;
    unique case (state)
      PS_RUN: begin
        if (!pending) begin
          if (idle_req)                 st_d = PS_IDLE;
          else if (stby_req && !disp_en) st_d = PS_STBY;
        end
      end
      PS_IDLE: if (pending) st_d = PS_RUN;
      PS_STBY: begin
        if (wake_hit) begin
          if (settle == '0) st_d = PS_RUN;
          else begin
            st_d  = PS_WAKE;
            cnt_d = settle - 1'b1;
          end
        end
      end
      PS_WAKE: begin
        if (cnt_q == '0) st_d = PS_RUN;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= PS_RUN;
      cnt_q     <= '0;
      violation <= 1'b0;
    end else begin
      state     <= st_d;
      cnt_q     <= cnt_d;
      violation <= stby_req && disp_en;
    end
  end

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NSRC   = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NSRC-1:0]   irq_src,
  input  logic [NSRC-1:0]   irq_wake_mask,
  input  logic              wake_i,
  input  logic              disp_en_i,
  input  logic [CNT_W-1:0]  settle_cycles,
  output logic              cpu_clk_en,
  output logic              osc_en,
  output logic              irq_pending,
  output logic              disp_violation,
  output logic [NSRC+1:0]   status
);

  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] flags;
  logic            idle_req, stby_req;
  pstate_e         state;

  pwr_addr_decode #(.ADDR_W(ADDR_W), .NSRC(NSRC)) u_dec (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .clr_vec  (clr_vec),
    .idle_req (idle_req),
    .stby_req (stby_req)
  );

  pwr_irq_bank #(.NSRC(NSRC)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (irq_src),
    .clr   (clr_vec),
    .flags (flags)
  );

  pwr_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_req  (idle_req),
    .stby_req  (stby_req),
    .pending   (irq_pending),
    .wake_hit  (wake_i || |(flags & irq_wake_mask)),
    .disp_en   (disp_en_i),
    .settle    (settle_cycles),
    .state     (state),
    .violation (disp_violation)
  );

  assign irq_pending = |flags;
  assign cpu_clk_en  = (state == PS_RUN);
  assign osc_en      = (state != PS_STBY);
  assign status      = {flags, state};

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk
  import pwr_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NSRC   = 6,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [NSRC-1:0]   irq_wake_mask,
  input logic              wake_i,
  input logic              disp_en_i,
  input logic [CNT_W-1:0]  settle_cycles,
  input logic              cpu_clk_en,
  input logic              osc_en,
  input logic              irq_pending,
  input logic              disp_violation,
  input logic [NSRC+1:0]   status
);

  localparam logic [ADDR_W-1:0] IA = ADDR_W'(IDLE_REQ_ADDR);
  localparam logic [ADDR_W-1:0] SA = ADDR_W'(STBY_REQ_ADDR);

  logic [1:0]      st;
  logic [NSRC-1:0] fl;
  assign st = status[1:0];
  assign fl = status[NSRC+1:2];

  a_r1_run_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> (cpu_clk_en && osc_en));

  a_r2_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && wr_en && wr_addr == IA && !irq_pending) |=> (st == 2'd1 && !cpu_clk_en && osc_en));

  a_r3_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && irq_pending) |=> (st == 2'd0));

  a_r4_stby_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |-> (!osc_en && !cpu_clk_en));

  a_r5_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && wr_en && (wr_addr == IA || wr_addr == SA) && irq_pending) |=> (st == 2'd0));

  a_r6_display_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SA && disp_en_i) |=> (st != 2'd2 && disp_violation));

  a_r10_stby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && !wake_i && (fl & irq_wake_mask) == '0) |=> (st == 2'd2));

  a_r11_zero_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && wake_i && settle_cycles == '0) |=> (st == 2'd0));

  a_r11_wake_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3) |-> (osc_en && !cpu_clk_en));

  a_r12_pending_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending == (fl != '0));

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.ADDR_W(ADDR_W), .NSRC(NSRC), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en          (wr_en),
  .wr_addr        (wr_addr),
  .irq_wake_mask  (irq_wake_mask),
  .wake_i         (wake_i),
  .disp_en_i      (disp_en_i),
  .settle_cycles  (settle_cycles),
  .cpu_clk_en     (cpu_clk_en),
  .osc_en         (osc_en),
  .irq_pending    (irq_pending),
  .disp_violation (disp_violation),
  .status         (status)
);

// File: tb/pwr_state_ctrl_tb.sv
module pwr_state_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [5:0]  irq_src = '0;
  logic [5:0]  irq_wake_mask = '0;
  logic        wake_i = 1'b0;
  logic        disp_en_i = 1'b0;
  logic [7:0]  settle_cycles = '0;
  logic        cpu_clk_en, osc_en, irq_pending, disp_violation;
  logic [7:0]  status;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwr_state_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .irq_src(irq_src), .irq_wake_mask(irq_wake_mask), .wake_i(wake_i),
    .disp_en_i(disp_en_i), .settle_cycles(settle_cycles),
    .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .irq_pending(irq_pending),
    .disp_violation(disp_violation), .status(status)
  );

  function automatic logic [5:0] eoi_of(input logic [15:0] a);
    case (a)
      16'h0700: eoi_of = 6'd1;
      16'h0740: eoi_of = 6'd2;
      16'h0780: eoi_of = 6'd4;
      16'h07C0: eoi_of = 6'd8;
      16'h1700: eoi_of = 6'd16;
      16'h1600: eoi_of = 6'd32;
      default:  eoi_of = 6'd0;
    endcase
  endfunction

  // Reference model advanced at each rising edge, built from the requirements
  logic [1:0] m_st;
  logic [5:0] m_fl, m_prev;
  logic [7:0] m_cnt;
  logic       m_viol;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 2'd0; m_fl = '0; m_prev = '0; m_cnt = '0; m_viol = 1'b0;
    end else begin
      logic pend;
      pend   = (m_fl != 0);
      m_viol = wr_en && wr_addr == 16'h0840 && disp_en_i;
      case (m_st)
        2'd0: if (wr_en && !pend) begin
                if (wr_addr == 16'h0800) m_st = 2'd1;
                else if (wr_addr == 16'h0840 && !disp_en_i) m_st = 2'd2;
              end
        2'd1: if (pend) m_st = 2'd0;
        2'd2: if (wake_i || (m_fl & irq_wake_mask) != 0) begin
                if (settle_cycles == 0) m_st = 2'd0;
                else begin m_st = 2'd3; m_cnt = settle_cycles - 8'd1; end
              end
        default: if (m_cnt == 0) m_st = 2'd0; else m_cnt = m_cnt - 8'd1;
      endcase
      if (wr_en) m_fl = m_fl & ~eoi_of(wr_addr);
      m_fl   = m_fl | (irq_src & ~m_prev);
      m_prev = irq_src;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      chk("R12 status", {24'd0, status}, {24'd0, m_fl, m_st});
      chk("R2 cpu_clk_en", {31'd0, cpu_clk_en}, {31'd0, m_st == 2'd0});
      chk("R4 osc_en", {31'd0, osc_en}, {31'd0, m_st != 2'd2});
      chk("R12 irq_pending", {31'd0, irq_pending}, {31'd0, m_fl != 0});
      chk("R6 disp_violation", {31'd0, disp_violation}, {31'd0, m_viol});
    end
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a);
    @(negedge clk); wr_en = 1'b1; wr_addr = a;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); irq_src[i] = 1'b1;
    @(negedge clk); irq_src[i] = 1'b0;
  endtask

  initial begin
    logic [15:0] alist [8];
    void'($urandom(32'd7001));
    alist = '{16'h0800, 16'h0840, 16'h0700, 16'h0740, 16'h0780, 16'h07C0, 16'h1700, 16'h1600};
    repeat (4) step();
    rst_n = 1'b1;
    step();
    mon_on = 1'b1;
    // R1 reset state
    chk("R1 status", {24'd0, status}, 32'd0);
    chk("R1 clocks", {30'd0, cpu_clk_en, osc_en}, 32'd3);
    // R2 Idle entry
    wr(16'h0800);
    chk("R2 idle", {24'd0, status}, 32'd1);
    chk("R2 clocks", {30'd0, cpu_clk_en, osc_en}, 32'd1);
    // R3 Idle exit on new latch
    pulse(0);
    step();
    chk("R3 exit", {24'd0, status}, {24'd0, 6'd1, 2'd0});
    // R5 request ignored while pending
    wr(16'h0800);
    chk("R5 idle blocked", {30'd0, status[1:0]}, 32'd0);
    wr(16'h0840);
    chk("R5 stby blocked", {30'd0, status[1:0]}, 32'd0);
    // R8 clear only the owning latch
    wr(16'h0700);
    chk("R8 clear bit0", {24'd0, status}, 32'd0);
    pulse(1); pulse(4);
    wr(16'h1700);
    chk("R8 clear bit4 only", {26'd0, status[7:2]}, 32'd2);
    wr(16'h0740);
    chk("R8 clear bit1", {26'd0, status[7:2]}, 32'd0);
    // R9 set and clear together, then R7 held level does not re-set
    @(negedge clk); irq_src[5] = 1'b1; wr_en = 1'b1; wr_addr = 16'h1600;
    @(negedge clk); wr_en = 1'b0;
    chk("R9 set wins", {31'd0, status[7]}, 32'd1);
    wr(16'h1600);
    step();
    chk("R7 held high stays clear", {31'd0, status[7]}, 32'd0);
    irq_src[5] = 1'b0;
    // R6 display blocks Standby
    disp_en_i = 1'b1;
    wr(16'h0840);
    chk("R6 no standby", {30'd0, status[1:0]}, 32'd0);
    chk("R6 violation", {31'd0, disp_violation}, 32'd1);
    step();
    chk("R6 pulse one cycle", {31'd0, disp_violation}, 32'd0);
    disp_en_i = 1'b0;
    // R4 Standby entry
    wr(16'h0840);
    chk("R4 standby", {30'd0, status[1:0]}, 32'd2);
    chk("R4 clocks off", {30'd0, cpu_clk_en, osc_en}, 32'd0);
    // R10 unmasked latch does not wake; clear works in Standby
    irq_wake_mask = 6'b001000;
    pulse(2);
    step();
    chk("R10 unmasked stays", {24'd0, status}, {24'd0, 6'd4, 2'd2});
    wr(16'h0780);
    chk("R8 clear in standby", {24'd0, status}, 32'd2);
    // R11 wake with settle 3
    settle_cycles = 8'd3;
    @(negedge clk); wake_i = 1'b1;
    @(negedge clk); wake_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R11 waking", {29'd0, status[1:0], cpu_clk_en}, {29'd0, 2'd3, 1'b0});
      chk("R11 osc on", {31'd0, osc_en}, 32'd1);
      step();
    end
    chk("R11 run after settle", {30'd0, status[1:0]}, 32'd0);
    // R11 zero settle via masked interrupt (R10)
    settle_cycles = 8'd0;
    wr(16'h0840);
    chk("R4 standby again", {30'd0, status[1:0]}, 32'd2);
    pulse(3);
    step();
    chk("R10 R11 masked wake direct", {24'd0, status}, {24'd0, 6'd8, 2'd0});
    wr(16'h07C0);
    // Random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 9) < 4);
      wr_addr = ($urandom_range(0, 9) == 0) ? 16'($urandom) : alist[$urandom_range(0, 7)];
      irq_src = ($urandom_range(0, 9) == 0) ? 6'($urandom) : irq_src & 6'($urandom);
      wake_i = ($urandom_range(0, 19) == 0);
      disp_en_i = ($urandom_range(0, 4) == 0);
      irq_wake_mask = 6'($urandom);
      settle_cycles = 8'($urandom_range(0, 5));
    end
    @(negedge clk);
    wr_en = 1'b0; irq_src = '0; wake_i = 1'b0;
    repeat (10) step();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule